// File: doc/BRIEF.md
# Control Register Zero Write Intercept Evaluator

This block decides whether a guest write to control register zero must leave the guest and return control to the hypervisor. For each evaluated instruction it receives the instruction kind, the register value before and after the write, and two enables. The generic write intercept traps every write. The selective write intercept traps only writes that change something beyond the task-switched and monitor-coprocessor bits. A flag that stands for the non-memory exception checks lets a pending exception take precedence over both intercepts.

The decision is made combinationally and registered once. For every instruction presented with `evalValid` high, the block produces a one-cycle `outValid` pulse on the next clock. With that pulse it reports whether an intercept fired, the exit code that tells the two intercept kinds apart, and whether the pending exception was taken instead.

Three instruction kinds are handled. The register move applies the selective comparison. The machine-status-word load treats the selective intercept as unconditional. The task-switched clear never consults the selective intercept.

Top module: `cr_wr_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `outValid`, `interceptHit`, `excTaken` and `exitCode` are all zero.
- R2: `outValid` is high exactly on the cycle after a cycle with `evalValid` high. While `outValid` is low, `interceptHit`, `excTaken` and `exitCode` are zero.
- R3: For kind 0 (register move), when the generic enable is clear, the selective enable is set and no exception is pending, an intercept fires with code `SEL_CODE` if and only if `oldVal ^ newVal` has a set bit other than bit 3 (task-switched) or bit 1 (monitor-coprocessor).
- R4: For kind 1 (status-word load), when the generic enable is clear, the selective enable is set and no exception is pending, an intercept always fires with code `SEL_CODE`, whatever the old and new values are.
- R5: For kind 2 (task-switched clear), the selective enable has no effect. With the generic enable clear, no intercept fires for any values.
- R6: When both enables are set and no exception is pending, kinds 0 to 2 report `GEN_CODE` and never `SEL_CODE`.
- R7: When `excPending` is high, `excTaken` is high, `interceptHit` is low and `exitCode` is zero, whatever the kind and the enables are.
- R8: For kinds 0 to 2 with the generic enable set and no exception pending, an intercept fires with code `GEN_CODE` for any values.
- R9: Kind 3 is reserved and never fires an intercept. `excTaken` still follows `excPending` for this kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | An instruction is presented for evaluation this cycle |
| instrKind | input | 2 | 0 = register move, 1 = status-word load, 2 = task-switched clear, 3 = reserved |
| oldVal | input | W | Register value before the write |
| newVal | input | W | Register value the write would produce |
| genEnable | input | 1 | Generic write intercept enabled |
| selEnable | input | 1 | Selective write intercept enabled |
| excPending | input | 1 | A non-memory exception check has failed for this instruction |
| outValid | output | 1 | One-cycle result pulse |
| interceptHit | output | 1 | The write causes an exit |
| exitCode | output | CW | `GEN_CODE`, `SEL_CODE`, or zero when there is no hit |
| excTaken | output | 1 | The pending exception wins over any intercept |

## Verification
A wrong mask bit or a swapped priority inside this block shows on the very next `outValid` pulse as a wrong `interceptHit` or `exitCode`. A wrong mask bit shows only for value pairs that differ in the affected bit. A wrong priority shows only under the enable combination that exposes it. For this reason the bench sweeps every kind against every enable and exception combination, with random values and directed values that differ only in the task-switched and monitor-coprocessor bits. Any latency or pulse-width error is caught on every cycle, because the reference model predicts the outputs of each cycle, idle cycles included.

// File: rtl/cr_wr_gate_pkg.sv
package cr_wr_gate_pkg;
  typedef enum logic [1:0] {
    KIND_MOVE = 2'd0,
    KIND_LMSW = 2'd1,
    KIND_CLTS = 2'd2,
    KIND_RSVD = 2'd3
  } wrKind_e;

  typedef struct packed {
    logic load;
    logic fireGen;
    logic fireSel;
    logic excWin;
  } gateStrobe_t;
endpackage

// File: rtl/cr_wr_gate_ctrl.sv
module cr_wr_gate_ctrl
  import cr_wr_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evalValid,
  input  logic [1:0]  instrKind,
  input  logic        genEnable,
  input  logic        selEnable,
  input  logic        excPending,
  input  logic        selDiff,
  output gateStrobe_t strobe
);
  wrKind_e kind;
  assign kind = wrKind_e'(instrKind);

  always_comb begin
    strobe      = '0;
    strobe.load = evalValid;
    if (evalValid) begin
      if (excPending) begin
        strobe.excWin = 1'b1;
      end else if (kind != KIND_RSVD) begin
        if (genEnable) begin
          strobe.fireGen = 1'b1;
        end else if (selEnable) begin
          unique case (kind)
            KIND_MOVE: strobe.fireSel = selDiff;
            KIND_LMSW: strobe.fireSel = 1'b1;
            default:   strobe.fireSel = 1'b0;
          endcase
        end
      end
    end
  end

  // R6: the generic intercept shadows the selective one
  a_r6_gen_first: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fireSel |-> !genEnable);
  // R5: the task-switched clear never raises the selective intercept
  a_r5_clts_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (evalValid && instrKind == 2'd2) |-> !strobe.fireSel);
  // R7: at most one outcome per instruction
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.fireGen, strobe.fireSel, strobe.excWin}));
endmodule

// File: rtl/cr_wr_gate_dp.sv
module cr_wr_gate_dp
  import cr_wr_gate_pkg::*;
#(
  parameter int W        = 32,
  parameter int CW       = 12,
  parameter int TS_BIT   = 3,
  parameter int MP_BIT   = 1,
  parameter logic [CW-1:0] GEN_CODE = 12'h010,
  parameter logic [CW-1:0] SEL_CODE = 12'h065
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  oldVal,
  input  logic [W-1:0]  newVal,
  input  gateStrobe_t   strobe,
  output logic          selDiff,
  output logic          outValid,
  output logic          interceptHit,
  output logic [CW-1:0] exitCode,
  output logic          excTaken
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] IGNORE_MASK = (ONE << TS_BIT) | (ONE << MP_BIT);

  logic [W-1:0] changed;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      if (IGNORE_MASK[b]) begin : g_skip
        assign changed[b] = 1'b0;
      end else begin : g_cmp
        assign changed[b] = oldVal[b] ^ newVal[b];
      end
    end
  endgenerate

  assign selDiff = |changed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid     <= 1'b0;
      interceptHit <= 1'b0;
      exitCode     <= '0;
      excTaken     <= 1'b0;
    end else begin
      outValid     <= strobe.load;
      interceptHit <= strobe.fireGen | strobe.fireSel;
      excTaken     <= strobe.excWin;
      if (strobe.fireGen)      exitCode <= GEN_CODE;
      else if (strobe.fireSel) exitCode <= SEL_CODE;
      else                     exitCode <= '0;
    end
  end

  // R2: one result pulse per evaluated instruction, one cycle later
  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> outValid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> !outValid);
  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!interceptHit && !excTaken && exitCode == '0));
  // R7: a taken exception excludes any intercept
  a_r7_exc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |-> (!interceptHit && exitCode == '0));
  // R3: a hit always carries one of the two exit codes
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    interceptHit |-> (exitCode == GEN_CODE || exitCode == SEL_CODE));
endmodule

// File: rtl/cr_wr_gate.sv
module cr_wr_gate
  import cr_wr_gate_pkg::*;
#(
  parameter int W        = 32,
  parameter int CW       = 12,
  parameter logic [CW-1:0] GEN_CODE = 12'h010,
  parameter logic [CW-1:0] SEL_CODE = 12'h065
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evalValid,
  input  logic [1:0]    instrKind,
  input  logic [W-1:0]  oldVal,
  input  logic [W-1:0]  newVal,
  input  logic          genEnable,
  input  logic          selEnable,
  input  logic          excPending,
  output logic          outValid,
  output logic          interceptHit,
  output logic [CW-1:0] exitCode,
  output logic          excTaken
);
  gateStrobe_t strobe;
  logic        selDiff;

  cr_wr_gate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evalValid(evalValid), .instrKind(instrKind),
    .genEnable(genEnable), .selEnable(selEnable), .excPending(excPending),
    .selDiff(selDiff), .strobe(strobe)
  );

  cr_wr_gate_dp #(
    .W(W), .CW(CW), .TS_BIT(3), .MP_BIT(1),
    .GEN_CODE(GEN_CODE), .SEL_CODE(SEL_CODE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .oldVal(oldVal), .newVal(newVal),
    .strobe(strobe), .selDiff(selDiff), .outValid(outValid),
    .interceptHit(interceptHit), .exitCode(exitCode), .excTaken(excTaken)
  );
endmodule

// File: tb/cr_wr_gate_tb.sv
module cr_wr_gate_tb;
  localparam int W  = 32;
  localparam int CW = 12;
  localparam logic [CW-1:0] GEN = 12'h010;
  localparam logic [CW-1:0] SEL = 12'h065;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evalValid = 1'b0;
  logic [1:0] instrKind = 2'd0;
  logic [W-1:0] oldVal = '0, newVal = '0;
  logic genEnable = 1'b0, selEnable = 1'b0, excPending = 1'b0;
  logic outValid, interceptHit, excTaken;
  logic [CW-1:0] exitCode;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cr_wr_gate #(.W(W), .CW(CW), .GEN_CODE(GEN), .SEL_CODE(SEL)) u_dut (
    .clk(clk), .rst_n(rst_n), .evalValid(evalValid), .instrKind(instrKind),
    .oldVal(oldVal), .newVal(newVal), .genEnable(genEnable),
    .selEnable(selEnable), .excPending(excPending), .outValid(outValid),
    .interceptHit(interceptHit), .exitCode(exitCode), .excTaken(excTaken)
  );

  // expectation for the next sample: valid, hit, exc, code, requirement tag
  bit expV, expH, expE;
  logic [CW-1:0] expC;
  string expTag;

  function automatic void predict(bit v, int k, logic [W-1:0] o, logic [W-1:0] n,
                                  bit g, bit s, bit x);
    logic [W-1:0] d;
    d = (o ^ n) & ~(32'h0000_0008 | 32'h0000_0002);
    expV = v; expH = 0; expE = 0; expC = '0; expTag = "R2";
    if (!v) return;
    if (x) begin expE = 1; expTag = "R7"; return; end
    if (k == 3) begin expTag = "R9"; return; end
    if (g) begin
      expH = 1; expC = GEN;
      expTag = s ? "R6" : "R8";
      return;
    end
    if (k == 2) begin expTag = "R5"; return; end
    if (!s) begin expTag = "R2"; return; end
    if (k == 1) begin expH = 1; expC = SEL; expTag = "R4"; return; end
    expTag = "R3";
    if (d != 0) begin expH = 1; expC = SEL; end
  endfunction

  task automatic compare();
    compared++;
    if (outValid !== expV || interceptHit !== expH || excTaken !== expE || exitCode !== expC) begin
      mismatched++;
      $display("FAIL %s: got v=%0b hit=%0b exc=%0b code=%h, expected v=%0b hit=%0b exc=%0b code=%h",
               expTag, outValid, interceptHit, excTaken, exitCode, expV, expH, expE, expC);
    end
  endtask

  // one cycle: check the previous prediction, then drive new inputs
  task automatic step(bit v, int k, logic [W-1:0] o, logic [W-1:0] n, bit g, bit s, bit x);
    @(negedge clk);
    compare();
    evalValid = v; instrKind = 2'(k); oldVal = o; newVal = n;
    genEnable = g; selEnable = s; excPending = x;
    predict(v, k, o, n, g, s, x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compared++;
    if (outValid !== 0 || interceptHit !== 0 || excTaken !== 0 || exitCode !== 0) begin
      mismatched++;
      $display("FAIL R1: got v=%0b hit=%0b exc=%0b code=%h, expected all zero",
               outValid, interceptHit, excTaken, exitCode);
    end
    rst_n = 1'b1;
    predict(0, 0, '0, '0, 0, 0, 0);   // R1: first cycle after reset is quiet

    // R3: changes confined to TS (bit 3) and MP (bit 1) are ignored
    step(1, 0, 32'h8000_0011, 32'h8000_001B, 0, 1, 0);
    step(1, 0, 32'h0000_000A, 32'h0000_0000, 0, 1, 0);
    step(1, 0, 32'h0000_0000, 32'h0000_0001, 0, 1, 0);
    step(1, 0, 32'h0000_0000, 32'h8000_0000, 0, 1, 0);
    step(1, 0, 32'h1234_5678, 32'h1234_5678, 0, 1, 0);
    // R4: status-word load with identical values still intercepts
    step(1, 1, 32'h0000_0033, 32'h0000_0033, 0, 1, 0);
    // R5: task-switched clear with a large change is not intercepted
    step(1, 2, 32'h0000_0000, 32'hFFFF_FFFF, 0, 1, 0);
    // R6: both enabled on a qualifying move
    step(1, 0, 32'h0, 32'h1, 1, 1, 0);
    // R7: exception wins over both intercepts
    step(1, 1, 32'h0, 32'h1, 1, 1, 1);
    // R2: idle gap, back-to-back pulses
    step(0, 0, 32'h0, 32'h1, 1, 1, 0);
    step(1, 3, 32'h0, 32'h1, 1, 1, 0);   // R9
    step(1, 3, 32'h0, 32'h1, 1, 1, 1);   // R9 with exception

    // sweep: every kind, enable pair and exception flag with random values
    for (int k = 0; k < 4; k++)
      for (int en = 0; en < 4; en++)
        for (int x = 0; x < 2; x++)
          for (int r = 0; r < 20; r++) begin
            logic [W-1:0] o, n;
            o = $urandom;
            n = (r % 3 == 0) ? (o ^ (($urandom & 32'hA) | 32'h0)) : $urandom;
            step((r % 7) != 6, k, o, n, en[1], en[0], x[0]);
          end

    step(0, 0, '0, '0, 0, 0, 0);
    step(0, 0, '0, '0, 0, 0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule